// File: doc/BRIEF.md
# Die Over-Temperature Guard

This block watches a digitized die temperature and decides, sample by sample, how the receiver should react to heat. A small configuration register picks a trip point (or turns protection off) and a hysteresis margin. From each valid temperature sample the block sorts the die into one of four bands relative to the trip point. Its outputs are a request that the link controller send an over-temperature stop packet to the transmitter, a latched hard shutdown for the local power stage, and a raw fault flag for the fault controller.

The stop request has its own hysteresis: it rises once the die is within a near window of the trip point and falls only once the die has cooled well below it, holding its state in the gap between. Shutdown fires when the die reaches the trip point plus the selected margin and stays on until the block is disabled or reset. All outputs are registered and change one clock after the sample that causes the change.

Top module: `dietemp_guard`

## Requirements
- R1: After reset the trip-point select is 1 (130 °C) and the margin select is 1 (20 °C), so the shutdown limit is 150 °C.
- R2: A write (`cfg_we` high) loads `cfg_wdata[1:0]` as trip-point select: 0 = protection off, 1 = 130 °C, 2 = 140 °C, 3 = 150 °C. The new value applies to samples from the next clock on.
- R3: The same write loads `cfg_wdata[2]` as margin select: 0 = 10 °C, 1 = 20 °C.
- R4: A valid sample at or above trip point plus margin sets `shutdown`, `over_temp_flag` and `stop_req`.
- R5: `shutdown` stays high once set, whatever later samples show, until `enable` goes low, the select becomes 0, or reset.
- R6: A valid sample at or above trip point minus 10 °C sets `stop_req`.
- R7: A valid sample more than 20 °C below the trip point clears `stop_req`.
- R8: A valid sample from exactly 20 °C below to 11 °C below the trip point leaves `stop_req` unchanged.
- R9: `over_temp_flag` follows each valid sample: high exactly when it is at or above trip point plus margin, low otherwise.
- R10: Samples with `temp_valid` low change no output.
- R11: While the trip-point select is 0, all three outputs are forced low at the next clock and all state is cleared.
- R12: While `enable` is low, all three outputs are forced low at the next clock and samples are ignored.
- R13: Every output is a register; a sample presented at clock edge k is reflected after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low clears and holds all outputs low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | [1:0] trip-point select, [2] margin select |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_c | input | TEMP_W | Unsigned die temperature in °C |
| stop_req | output | 1 | Request to send an over-temperature stop packet |
| shutdown | output | 1 | Latched local hard shutdown |
| over_temp_flag | output | 1 | Raw die over-temperature fault flag |

## Verification
The bench aims at the exact band edges: trip point minus 10, trip point minus 20 and minus 21, and trip plus margin minus one; a design with an off-by-one compare would raise or drop the stop request one degree early or miss shutdown at the limit. It cools the die after a shutdown to show that the shutdown latch survives while the raw flag falls, which a design that tied both together would fail. It writes a new configuration and samples on the following cycle, and selects protection off while shutdown is set, catching designs that use stale settings or keep state in off mode. Long stretches of hot samples with the strobe low show that an unqualified sample path would trip.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  // Temperature band relative to the selected trip point
  typedef enum logic [1:0] {
    BAND_COOL = 2'd0,  // far below trip point: drop stop request
    BAND_HOLD = 2'd1,  // hysteresis gap: keep stop request
    BAND_NEAR = 2'd2,  // close to / above trip point: raise stop request
    BAND_TRIP = 2'd3   // at or above trip point plus margin
  } band_e;

  typedef struct packed {
    logic       hyst_hi;
    logic [1:0] thr_sel;
  } guard_cfg_t;

  localparam guard_cfg_t CFG_RESET = '{hyst_hi: 1'b1, thr_sel: 2'd1};

endpackage

// File: rtl/dtp_cfg_reg.sv
module dtp_cfg_reg
  import dtp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output guard_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_we) begin
      cfg_q.thr_sel <= cfg_wdata[1:0];
      cfg_q.hyst_hi <= cfg_wdata[2];
    end
  end

  // R1: configuration comes out of reset at 130 C / 20 C
  a_r1_cfg_reset: assert property (@(posedge clk)
    rst |=> (cfg_q.thr_sel == 2'd1 && cfg_q.hyst_hi));

  // R2: an unwritten configuration is stable
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/dtp_band.sv
module dtp_band
  import dtp_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int THR_BASE = 130,
  parameter int THR_STEP = 10,
  parameter int HYST_LO  = 10,
  parameter int HYST_HI  = 20,
  parameter int NEAR_WIN = 10,
  parameter int FAR_WIN  = 20
) (
  input  logic [TEMP_W-1:0] temp_c,
  input  guard_cfg_t        cfg,
  output band_e             band,
  output logic              active
);

  localparam int CW = ((TEMP_W > 12) ? TEMP_W : 12) + 2;

  logic [1:0]    sel_idx;
  logic [CW-1:0] thr;
  logic [CW-1:0] lim;
  logic [CW-1:0] t_ext;
  logic          is_trip;
  logic          is_near;
  logic          is_cool;

  always_comb begin
    sel_idx = (cfg.thr_sel == 2'd0) ? 2'd0 : (cfg.thr_sel - 2'd1);
    thr     = CW'(THR_BASE) + CW'(THR_STEP) * CW'(sel_idx);
    lim     = thr + (cfg.hyst_hi ? CW'(HYST_HI) : CW'(HYST_LO));
    t_ext   = CW'(temp_c);
    is_trip = (t_ext >= lim);
    is_near = ((t_ext + CW'(NEAR_WIN)) >= thr);
    is_cool = ((t_ext + CW'(FAR_WIN)) < thr);
  end

  always_comb begin
    if (is_trip)      band = BAND_TRIP;
    else if (is_near) band = BAND_NEAR;
    else if (is_cool) band = BAND_COOL;
    else              band = BAND_HOLD;
  end

  assign active = (cfg.thr_sel != 2'd0);

endmodule

// File: rtl/dtp_ctrl.sv
module dtp_ctrl
  import dtp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  enable,
  input  logic  active,
  input  logic  temp_valid,
  input  band_e band,
  output logic  stop_req,
  output logic  shutdown,
  output logic  over_temp_flag
);

  logic run;
  assign run = enable && active;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      stop_req       <= 1'b0;
      shutdown       <= 1'b0;
      over_temp_flag <= 1'b0;
    end else if (temp_valid) begin
      unique case (band)
        BAND_TRIP: begin
          stop_req       <= 1'b1;
          shutdown       <= 1'b1;
          over_temp_flag <= 1'b1;
        end
        BAND_NEAR: begin
          stop_req       <= 1'b1;
          over_temp_flag <= 1'b0;
        end
        BAND_COOL: begin
          stop_req       <= 1'b0;
          over_temp_flag <= 1'b0;
        end
        default: begin
          over_temp_flag <= 1'b0;
        end
      endcase
    end
  end

  // R4: a trip-band sample raises all three outputs
  a_r4_trip_sets_all: assert property (@(posedge clk) disable iff (rst)
    (run && temp_valid && band == BAND_TRIP) |=> (shutdown && over_temp_flag && stop_req));

  // R5: shutdown persists while the block keeps running
  a_r5_shutdown_latched: assert property (@(posedge clk) disable iff (rst)
    (shutdown && run) |=> shutdown);

  // R7: a cool-band sample drops the stop request
  a_r7_cool_clears_req: assert property (@(posedge clk) disable iff (rst)
    (run && temp_valid && band == BAND_COOL) |=> !stop_req);

  // R10: no strobe, no change
  a_r10_no_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !temp_valid) |=> ($stable(stop_req) && $stable(over_temp_flag)));

  // R11 / R12: off mode or disable forces outputs low
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!stop_req && !shutdown && !over_temp_flag));

endmodule

// File: rtl/dietemp_guard.sv
module dietemp_guard
  import dtp_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int THR_BASE = 130,
  parameter int THR_STEP = 10,
  parameter int HYST_LO  = 10,
  parameter int HYST_HI  = 20,
  parameter int NEAR_WIN = 10,
  parameter int FAR_WIN  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wdata,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              stop_req,
  output logic              shutdown,
  output logic              over_temp_flag
);

  guard_cfg_t cfg_q;
  band_e      band;
  logic       active;

  dtp_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  dtp_band #(
    .TEMP_W   (TEMP_W),
    .THR_BASE (THR_BASE),
    .THR_STEP (THR_STEP),
    .HYST_LO  (HYST_LO),
    .HYST_HI  (HYST_HI),
    .NEAR_WIN (NEAR_WIN),
    .FAR_WIN  (FAR_WIN)
  ) u_band (
    .temp_c (temp_c),
    .cfg    (cfg_q),
    .band   (band),
    .active (active)
  );

  dtp_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .active         (active),
    .temp_valid     (temp_valid),
    .band           (band),
    .stop_req       (stop_req),
    .shutdown       (shutdown),
    .over_temp_flag (over_temp_flag)
  );

  // R9 / R4: raw flag high implies shutdown was set on that same sample
  a_r9_flag_implies_sd: assert property (@(posedge clk) disable iff (rst)
    over_temp_flag |-> shutdown);

  // R13: outputs leave reset low
  a_r13_reset_low: assert property (@(posedge clk)
    rst |=> (!stop_req && !shutdown && !over_temp_flag));

endmodule

// File: tb/dietemp_guard_bench.sv
`timescale 1ns/1ps
module dietemp_guard_bench;

  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_wdata = 3'd0;
  logic          temp_valid = 1'b0;
  logic [TW-1:0] temp_c = '0;
  logic          stop_req, shutdown, over_temp_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done    = 0;

  // reference model state
  int m_sel = 1, m_hy = 1;
  bit m_req = 0, m_sd = 0, m_flt = 0;

  always #4 clk = ~clk;  // 125 MHz

  dietemp_guard #(.TEMP_W(TW)) u_dietemp_guard (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .temp_valid(temp_valid), .temp_c(temp_c),
    .stop_req(stop_req), .shutdown(shutdown), .over_temp_flag(over_temp_flag)
  );

  // behavioural reference: evaluate with the old configuration, then load
  always @(posedge clk) begin
    if (rst) begin
      m_sel = 1; m_hy = 1; m_req = 0; m_sd = 0; m_flt = 0;
    end else begin
      if (!enable || m_sel == 0) begin
        m_req = 0; m_sd = 0; m_flt = 0;
      end else if (temp_valid) begin
        int thr, lim, t;
        thr = 120 + 10 * m_sel;
        lim = thr + (m_hy ? 20 : 10);
        t   = int'(temp_c);
        if (t >= lim) begin
          m_sd = 1; m_flt = 1; m_req = 1;
        end else begin
          m_flt = 0;
          if (t + 10 >= thr)     m_req = 1;
          else if (t + 20 < thr) m_req = 0;
        end
      end
      if (cfg_we) begin
        m_sel = int'(cfg_wdata[1:0]);
        m_hy  = int'(cfg_wdata[2]);
      end
    end
  end

  // every-cycle comparison against the model (R13 latency, all bands)
  always @(negedge clk) begin
    if (started && !done) begin
      n_tests++;
      if ({stop_req, shutdown, over_temp_flag} !== {m_req, m_sd, m_flt}) begin
        n_fail++;
        $display("FAIL R13 model compare t=%0t: req/sd/flt actual %b%b%b expected %b%b%b",
                 $time, stop_req, shutdown, over_temp_flag, m_req, m_sd, m_flt);
      end
    end
  end

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: req/sd/flt actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {stop_req, shutdown, over_temp_flag};
  endfunction

  task automatic sample(input int t);
    temp_c = TW'(t); temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic write_cfg(input logic [2:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_disable();
    enable = 1'b0;
    @(negedge clk);
    check("R12 disable clears", outs(), 3'b000);
    enable = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    started = 1;
    check("R13 reset state", outs(), 3'b000);

    // default 130 C trip, 20 C margin
    sample(149); check("R1 R6 below limit", outs(), 3'b100);
    sample(150); check("R1 R4 at limit", outs(), 3'b111);
    sample(100); check("R5 R9 R7 cooled", outs(), 3'b010);
    pulse_disable();
    sample(120); check("R6 edge T-10", outs(), 3'b100);
    sample(110); check("R8 hold at T-20", outs(), 3'b100);
    sample(109); check("R7 clear at T-21", outs(), 3'b000);
    sample(115); check("R8 hold low", outs(), 3'b000);

    temp_c = 8'd200;
    repeat (4) @(negedge clk);
    check("R10 no strobe", outs(), 3'b000);

    write_cfg(3'b010);  // 140 C, 10 C margin
    sample(149); check("R2 R3 140/10 below", outs(), 3'b100);
    sample(150); check("R2 R3 140/10 trip", outs(), 3'b111);
    pulse_disable();

    write_cfg(3'b111);  // 150 C, 20 C margin
    sample(169); check("R2 R3 150/20 below", outs(), 3'b100);
    sample(170); check("R4 150/20 trip", outs(), 3'b111);
    pulse_disable();

    write_cfg(3'b101);  // back to 130 C, 20 C
    sample(160); check("R4 re-trip", outs(), 3'b111);
    write_cfg(3'b000);  // off: applies at the following edge
    @(negedge clk);
    check("R11 off clears latch", outs(), 3'b000);
    sample(220); check("R11 off ignores hot", outs(), 3'b000);

    enable = 1'b0;
    write_cfg(3'b101);
    sample(200); check("R12 disabled ignores hot", outs(), 3'b000);
    enable = 1'b1;

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      temp_valid = ($urandom_range(0, 3) != 0);
      temp_c     = TW'($urandom_range(95, 185));
      cfg_we     = ($urandom_range(0, 60) == 0);
      cfg_wdata  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 80) == 0) enable = ~enable;
      @(negedge clk);
    end
    cfg_we = 1'b0; temp_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule